// File: doc/BRIEF.md
# Variable-Rate Sample Slot Requester

This block paces audio samples over a serial audio link whose frames always arrive at 48 kHz, so that playback and record can each run at a lower programmed rate. It has two independent channels. The playback channel decides, once per frame, whether the controller is asked for the next left/right sample pair. The record channel decides whether a left/right record sample pair is marked valid in that frame.

Each channel keeps a 16-bit rate value with 1 Hz resolution and a phase accumulator. On every frame strobe, while variable-rate mode is on, the rate is added to the accumulator. When the sum reaches 48000, 48000 is taken off and the frame carries a sample event. While variable-rate mode is off, every frame carries a sample in both directions. Rate and mode values come in through a simple write port. The decisions are registered at the frame strobe and held until the next one.

Top module: `vra_slot_pacer`

## Requirements
- R1: After reset, both rates are 48000, variable-rate mode is off, both accumulators are 0, both playback request outputs are 1 (no request) and both record tag outputs are 0.
- R2: While variable-rate mode is off, every frame strobe produces a sample event in both directions.
- R3: While variable-rate mode is on, each frame strobe adds the channel rate to its accumulator. When the sum is at least 48000, the frame is a sample event and the accumulator keeps the sum minus 48000. Otherwise it keeps the sum.
- R4: The playback request outputs are active-low. A playback sample event drives both of them to 0 (controller must send the next pair), and a frame without one drives both to 1.
- R5: A record sample event drives both record tag outputs to 1, and a frame without one drives both to 0.
- R6: The four outputs change only at a clock edge where the frame strobe is high. They are held at all other edges.
- R7: A rate write (wr_sel 1 = playback, wr_sel 2 = record) stores the value clamped to the range 4000 to 48000.
- R8: A rate write clears that channel's accumulator and leaves the other channel alone. A frame strobe in the same cycle is decided from the old rate and accumulator, and the accumulator still ends at 0.
- R9: A write with wr_sel 0 sets variable-rate mode from wr_data bit 0. Writing 0 clears both accumulators, and they stay at 0 while the mode is off.
- R10: Starting from a cleared accumulator with variable-rate mode on, the number of sample events over 48000 consecutive frames equals the stored rate exactly.
- R11: A write with wr_sel 3 has no effect on the mode, the rates or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per link frame |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 playback rate, 2 record rate, 3 none |
| wr_data | input | 16 | Write value |
| play_req_l_n | output | 1 | Left playback request, 0 = send sample next frame |
| play_req_r_n | output | 1 | Right playback request, 0 = send sample next frame |
| rec_tag_l | output | 1 | Left record sample valid in this frame |
| rec_tag_r | output | 1 | Right record sample valid in this frame |

## Verification
The accumulator is not visible at the ports. A wrong phase value or a lost subtraction shows up as a shifted or missing event. At low rates this can take several frames to appear, so the bench keeps a behavioural model of both channels and compares all four outputs on every clock. A slow drift in cadence would pass a short comparison, so long runs of 48000 back-to-back frames count the events and check them against the stored rate exactly. The clamped rates are exposed through these same counts. Writes that collide with a frame strobe, and writes to the unused select, are placed so that any error shows up at the next strobe.

// File: rtl/vra_pace_pkg.sv
// Package: shared write-select encoding for the variable-rate pacer.
// Assumes a two-bit select field on the write port.
package vra_pace_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PLAY = 2'd1,
        SEL_REC  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/vra_mode_reg.sv
// Module: variable-rate mode enable bit.
// Holds a single enable that is written through the shared write port
// (select SEL_CTRL, data bit 0). Resets to 0 (fixed 48 kHz pacing).
module vra_mode_reg
    import vra_pace_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [RATE_W-1:0] wr_data,
    output logic              vra_en,
    output logic              vra_off_wr
);

    logic hit;

    // Decode a write aimed at the mode register.
    always_comb begin
        hit        = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
        vra_off_wr = hit && !wr_data[0];
    end

    // Store the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vra_en <= 1'b0;
        end else if (hit) begin
            vra_en <= wr_data[0];
        end
    end

    AST_MODE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (vra_en == $past(wr_data[0])));   // R9

endmodule

// File: rtl/vra_rate_reg.sv
// Module: one channel's rate register with range clamping.
// Responds to writes whose select equals CHAN_SEL. Values below MIN_RATE
// or above MAX_RATE are stored as the nearest limit. Pulses rate_wr for
// the write cycle so the accumulator can be cleared.
module vra_rate_reg
    import vra_pace_pkg::*;
#(
    parameter int       RATE_W     = 16,
    parameter int       MIN_RATE   = 4000,
    parameter int       MAX_RATE   = 48000,
    parameter int       RESET_RATE = 48000,
    parameter reg_sel_e CHAN_SEL   = SEL_PLAY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [RATE_W-1:0] wr_data,
    output logic [RATE_W-1:0] rate,
    output logic              rate_wr
);

    localparam logic [RATE_W-1:0] LO  = RATE_W'(MIN_RATE);
    localparam logic [RATE_W-1:0] HI  = RATE_W'(MAX_RATE);
    localparam logic [RATE_W-1:0] RST = RATE_W'(RESET_RATE);

    logic [RATE_W-1:0] clamped;

    // Detect a write to this channel and clamp the value into range.
    always_comb begin
        rate_wr = wr_en && (reg_sel_e'(wr_sel) == CHAN_SEL);
        if (wr_data < LO) begin
            clamped = LO;
        end else if (wr_data > HI) begin
            clamped = HI;
        end else begin
            clamped = wr_data;
        end
    end

    // Hold the channel rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate <= RST;
        end else if (rate_wr) begin
            rate <= clamped;
        end
    end

    AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rate >= LO) && (rate <= HI));   // R7

    AST_RATE_INRANGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_wr && wr_data >= LO && wr_data <= HI) |=> (rate == $past(wr_data)));   // R7

endmodule

// File: rtl/vra_phase_acc.sv
// Module: per-channel phase accumulator and sample-event decision.
// On a frame with variable-rate on, adds the rate and subtracts FRAME_HZ
// when the sum reaches it. With variable-rate off, every frame is an event
// and the phase is left untouched. Clear wins over stepping for the stored
// phase; the event of a colliding frame uses the old phase.
module vra_phase_acc #(
    parameter int RATE_W   = 16,
    parameter int FRAME_HZ = 48000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              vra_i,
    input  logic              clear_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              hit_o
);

    localparam int ACC_W = $clog2(2 * FRAME_HZ) + 1;
    localparam logic [ACC_W-1:0] WRAP = ACC_W'(FRAME_HZ);

    logic [ACC_W-1:0] sum;
    logic             over;
    logic [ACC_W-1:0] acc_nxt;

    // Form the stepped phase and the event decision.
    always_comb begin
        sum     = acc_o + ACC_W'(rate_i);
        over    = (sum >= WRAP);
        hit_o   = frame_i && (!vra_i || over);
        acc_nxt = acc_o;
        if (frame_i && vra_i) begin
            acc_nxt = over ? (sum - WRAP) : sum;
        end
        if (clear_i) begin
            acc_nxt = '0;
        end
    end

    // Store the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else begin
            acc_o <= acc_nxt;
        end
    end

    AST_ACC_BELOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o < WRAP);   // R3

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_o == '0));   // R8

    AST_IDLE_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_i && !clear_i) |=> $stable(acc_o));   // R3

endmodule

// File: rtl/vra_slot_pacer.sv
// Module: variable-rate sample slot requester (top).
// Two channels: index 0 paces playback (active-low request pair), index 1
// paces record (active-high valid tag pair). The output flags are
// registered at each frame strobe and held until the next. Assumes
// frame_stb is a single-cycle pulse per link frame, synchronous to clk.
module vra_slot_pacer
    import vra_pace_pkg::*;
#(
    parameter int RATE_W     = 16,
    parameter int FRAME_HZ   = 48000,
    parameter int MIN_RATE   = 4000,
    parameter int MAX_RATE   = 48000,
    parameter int RESET_RATE = 48000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [RATE_W-1:0] wr_data,
    output logic              play_req_l_n,
    output logic              play_req_r_n,
    output logic              rec_tag_l,
    output logic              rec_tag_r
);

    localparam int NUM_CH = 2;
    localparam int ACC_W  = $clog2(2 * FRAME_HZ) + 1;

    logic              vra_en;
    logic              vra_off_wr;
    logic [RATE_W-1:0] rate    [NUM_CH];
    logic              rate_wr [NUM_CH];
    logic [ACC_W-1:0]  acc     [NUM_CH];
    logic              hit     [NUM_CH];
    logic [1:0]        flag_q  [NUM_CH];

    vra_mode_reg #(
        .RATE_W (RATE_W)
    ) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .vra_en     (vra_en),
        .vra_off_wr (vra_off_wr)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam reg_sel_e SEL = (ch == 0) ? SEL_PLAY : SEL_REC;

        vra_rate_reg #(
            .RATE_W     (RATE_W),
            .MIN_RATE   (MIN_RATE),
            .MAX_RATE   (MAX_RATE),
            .RESET_RATE (RESET_RATE),
            .CHAN_SEL   (SEL)
        ) u_rate (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_sel  (wr_sel),
            .wr_data (wr_data),
            .rate    (rate[ch]),
            .rate_wr (rate_wr[ch])
        );

        vra_phase_acc #(
            .RATE_W   (RATE_W),
            .FRAME_HZ (FRAME_HZ)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .frame_i (frame_stb),
            .vra_i   (vra_en),
            .clear_i (rate_wr[ch] || vra_off_wr),
            .rate_i  (rate[ch]),
            .acc_o   (acc[ch]),
            .hit_o   (hit[ch])
        );

        if (ch == 0) begin : g_play
            // Playback: register the active-low request pair each frame.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q[ch] <= 2'b11;
                end else if (frame_stb) begin
                    flag_q[ch] <= {2{~hit[ch]}};
                end
            end
        end else begin : g_rec
            // Record: register the active-high valid tag pair each frame.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q[ch] <= 2'b00;
                end else if (frame_stb) begin
                    flag_q[ch] <= {2{hit[ch]}};
                end
            end
        end

        AST_PHASE_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
            !vra_en |-> (acc[ch] == '0));   // R9
    end

    // Drive the ports from the channel flags.
    always_comb begin
        play_req_l_n = flag_q[0][1];
        play_req_r_n = flag_q[0][0];
        rec_tag_l    = flag_q[1][1];
        rec_tag_r    = flag_q[1][0];
    end

    AST_FIXED_EVERY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !vra_en) |=> (!play_req_l_n && !play_req_r_n && rec_tag_l && rec_tag_r));   // R2

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(play_req_l_n) && $stable(play_req_r_n)
                        && $stable(rec_tag_l) && $stable(rec_tag_r)));   // R6

    AST_UNUSED_SEL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> ($stable(vra_en) && $stable(rate[0]) && $stable(rate[1])));   // R11

    AST_PLAY_EVENT_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && hit[0]) |=> (!play_req_l_n && !play_req_r_n));   // R4

    AST_REC_EVENT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && hit[1]) |=> (rec_tag_l && rec_tag_r));   // R5

endmodule

// File: tb/vra_slot_pacer_bench.sv
module vra_slot_pacer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        play_req_l_n, play_req_r_n, rec_tag_l, rec_tag_r;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_tag = "R1";

    // behavioural reference state
    int  m_rate_p = 48000, m_rate_r = 48000;
    int  m_acc_p = 0, m_acc_r = 0;
    bit  m_vra = 0;
    bit  e_play_n = 1, e_rec = 0;

    // event counting
    bit counting = 0;
    int cnt_play = 0, cnt_rec = 0;

    always #10 clk = ~clk;

    vra_slot_pacer u_vra_slot_pacer (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_stb    (frame_stb),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .play_req_l_n (play_req_l_n),
        .play_req_r_n (play_req_r_n),
        .rec_tag_l    (rec_tag_l),
        .rec_tag_r    (rec_tag_r)
    );

    function automatic int clampr(int v);
        if (v < 4000) return 4000;
        if (v > 48000) return 48000;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model step and per-clock comparison
    always @(posedge clk) begin
        bit fs;
        int s;
        bit ep, er;
        cycles++;
        fs = 0;
        if (!rst_n) begin
            m_rate_p = 48000; m_rate_r = 48000;
            m_acc_p = 0; m_acc_r = 0; m_vra = 0;
            e_play_n = 1; e_rec = 0;
        end else begin
            fs = frame_stb;
            if (frame_stb) begin
                if (!m_vra) begin
                    ep = 1; er = 1;
                end else begin
                    s = m_acc_p + m_rate_p; ep = (s >= 48000); m_acc_p = ep ? s - 48000 : s;
                    s = m_acc_r + m_rate_r; er = (s >= 48000); m_acc_r = er ? s - 48000 : s;
                end
                e_play_n = !ep;
                e_rec    = er;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: begin
                        m_vra = wr_data[0];
                        if (!wr_data[0]) begin m_acc_p = 0; m_acc_r = 0; end
                    end
                    2'd1: begin m_rate_p = clampr(int'(wr_data)); m_acc_p = 0; end
                    2'd2: begin m_rate_r = clampr(int'(wr_data)); m_acc_r = 0; end
                    default: ;
                endcase
            end
        end
        #5;
        chk(play_req_l_n == e_play_n && play_req_r_n == e_play_n,
            {cur_tag, " R4 playback pair"}, {play_req_l_n, play_req_r_n}, {e_play_n, e_play_n});
        chk(rec_tag_l == e_rec && rec_tag_r == e_rec,
            {cur_tag, " R5 record pair"}, {rec_tag_l, rec_tag_r}, {e_rec, e_rec});
        if (counting && fs) begin
            if (!play_req_l_n) cnt_play++;
            if (rec_tag_l) cnt_rec++;
        end
    end

    task automatic tick();
        @(negedge clk);
        frame_stb = 1'b0;
        wr_en     = 1'b0;
    endtask

    task automatic do_write(logic [1:0] sel, logic [15:0] d, bit with_frame);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; frame_stb = with_frame;
        tick();
    endtask

    task automatic frames(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_stb = 1'b1;
            for (int g = 0; g < gap; g++) tick();
            if (gap == 0) begin @(negedge clk); frame_stb = 1'b0; end
        end
    endtask

    task automatic count_run(int exp_p, int exp_r, string tag);
        cnt_play = 0; cnt_rec = 0;
        counting = 1;
        @(negedge clk);
        frame_stb = 1'b1;
        repeat (48000) @(negedge clk);
        frame_stb = 1'b0;
        @(negedge clk);
        counting = 0;
        chk(cnt_play == exp_p, {tag, " playback event count"}, cnt_play, exp_p);
        chk(cnt_rec == exp_r, {tag, " record event count"}, cnt_rec, exp_r);
    endtask

    // watchdog
    initial begin
        wait (cycles > 190000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values at the ports
        chk(play_req_l_n && play_req_r_n && !rec_tag_l && !rec_tag_r, "R1 reset outputs",
            {play_req_l_n, play_req_r_n, rec_tag_l, rec_tag_r}, 4'b1100);

        // R2: fixed mode, every frame carries a sample
        cur_tag = "R2";
        frames(5, 3);
        chk(!play_req_l_n && rec_tag_r, "R2 fixed-mode frame event", {play_req_l_n, rec_tag_r}, 2'b01);
        // R10 on defaults after enabling: 48000 rate gives every frame
        do_write(2'd0, 16'h0001, 0);
        cur_tag = "R3";
        do_write(2'd1, 16'h1F40, 0);
        do_write(2'd2, 16'h2B11, 0);
        frames(150, 2);
        // R6: idle cycles keep outputs
        cur_tag = "R6";
        repeat (10) tick();

        // R7 clamp, R10 count over 48000 frames
        cur_tag = "R7";
        do_write(2'd1, 16'd1000, 0);
        do_write(2'd2, 16'd60000, 0);
        count_run(4000, 48000, "R7 R10");

        cur_tag = "R10";
        do_write(2'd1, 16'h5622, 0);
        do_write(2'd2, 16'hAC44, 0);
        count_run(22050, 44100, "R10");

        // R8: write colliding with a frame
        cur_tag = "R8";
        do_write(2'd1, 16'h3E80, 0);
        frames(2, 2);
        do_write(2'd1, 16'h3E80, 1);
        frames(6, 2);
        do_write(2'd2, 16'h1F40, 1);
        frames(12, 1);

        // R11: unused select has no effect
        cur_tag = "R11";
        do_write(2'd3, 16'h0000, 0);
        frames(6, 2);
        do_write(2'd3, 16'h0000, 1);
        frames(6, 2);

        // R9: turning the mode off returns to every-frame pacing
        cur_tag = "R9";
        do_write(2'd0, 16'h0000, 0);
        frames(4, 2);
        chk(!play_req_r_n && rec_tag_l, "R9 fixed pacing after disable", {play_req_r_n, rec_tag_l}, 2'b01);
        do_write(2'd0, 16'h0001, 0);
        frames(20, 1);

        repeat (4) tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule